// File: doc/BRIEF.md
# Strided Banked Vector Memory

This block serves vector loads and stores from a memory split into word-interleaved banks. A request gives a base word address, a stride and an element count. An address generator then steps through the elements in order. Element i sits at base + i × stride, taken modulo the address space. Each cycle the generator offers at most one element to the bank that the element's low address bits select.

After a bank accepts an access it must rest for a fixed number of cycles. The generator holds the current element until its bank is free again, and never reorders elements. For this reason the element rate depends on how the stride falls across the banks. Unit stride runs at one element per cycle. A stride that hits the same bank every time runs at one element per rest period.

Loads return one word per element after a fixed latency, each tagged with its element index. For stores, the write data is taken from an input that the client drives from the element index the block presents. A single-cycle completion pulse marks the end of every operation. A new request is taken only while the unit is idle.

Top module: `strided_bank_mem`

## Requirements
- R1: While reset is high, and on the first cycle after it, req_ready is 1 and rd_valid and done are 0.
- R2: Element i uses word address (base + i*stride) mod 2^ADDR_W. The bank is the low log2(NUM_BANKS) address bits and the row is the remaining high bits. A stride of all ones therefore walks addresses downward, wrapping through zero.
- R3: A store writes, for element i, the st_data value present in the cycle when st_idx equals i and that element issues. A later load of that address returns it.
- R4: An element issued in cycle c returns on rd_valid/rd_data in cycle c+LATENCY (12). With all banks free, element 0 issues in the cycle after the request is accepted, so a one-element load returns 13 cycles after the request cycle.
- R5: A bank that accepts an access in cycle c accepts nothing before cycle c+BUSY_CYCLES (4). When the next element's bank is still resting, issue stalls. A stride of 16 therefore returns one element per 4 cycles, and a stride of 8 returns pairs of elements every 4 cycles.
- R6: Unit stride over the 16 banks issues one element per cycle with no stall, so a 64-element load completes 76 cycles after its request cycle.
- R7: Load results come back strictly in element order, with rd_idx = 0, 1, …, len-1.
- R8: done is high for exactly one cycle per operation. For a load this is the cycle that carries the last element. For a store it is LATENCY cycles after the last element issues.
- R9: A request is accepted only in a cycle where req_ready is 1. req_valid while the unit is busy is ignored: it causes no extra return and no memory write.
- R10: Lengths from 1 to MAX_VLEN (64) are honoured exactly. A request with length 0 is ignored, and the unit stays idle with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_base | input | ADDR_W | Word address of element 0 |
| req_stride | input | ADDR_W | Address step between elements (modulo 2^ADDR_W) |
| req_len | input | IDX_W+1 | Element count, 1..MAX_VLEN |
| req_ready | output | 1 | Unit idle; a request in this cycle is taken |
| st_idx | output | IDX_W | Element index whose store data is wanted now |
| st_data | input | DATA_W | Store data for element st_idx |
| rd_valid | output | 1 | Load word valid |
| rd_idx | output | IDX_W | Element index of the returned word |
| rd_data | output | DATA_W | Returned load word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps a bank-rest model, so every returned word is checked against the exact cycle it must appear in. A design that ignored the rest time would return a same-bank stride too early, and one that stalled too long would return it late. Stride 8 lands on two banks and stride 16 on one. A stride of all ones runs downward through address zero, which catches an address adder that truncates or a bank field taken from the wrong bits. The bench drives a store request while a long load is running, then reads the region back; a unit that takes requests while busy would corrupt that region or produce unexpected returns. A zero-length request and a one-element load test the last-element detection: an off-by-one there would hang the unit or emit an extra word.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } agen_state_e;
endpackage

// File: rtl/sbm_agen.sv
module sbm_agen
  import sbm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 16,
  parameter int MAX_VLEN  = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(MAX_VLEN),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [ADDR_W-1:0]    req_stride,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [NUM_BANKS-1:0] bank_free,
  input  logic                 ret_done,
  output logic                 req_ready,
  output logic                 issue,
  output logic [ADDR_W-1:0]    iss_addr,
  output logic [BANK_W-1:0]    iss_bank,
  output logic [IDX_W-1:0]     iss_idx,
  output logic                 iss_last,
  output logic                 iss_write
);
  agen_state_e          state;
  logic [ADDR_W-1:0]    addr_q;
  logic [ADDR_W-1:0]    stride_q;
  logic [LEN_W-1:0]     len_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 wr_q;
  logic                 len_ok;

  assign len_ok    = (req_len != '0) && (req_len <= LEN_W'(MAX_VLEN));
  assign req_ready = (state == ST_IDLE);
  assign iss_addr  = addr_q;
  assign iss_bank  = addr_q[BANK_W-1:0];
  assign iss_idx   = idx_q;
  assign iss_write = wr_q;
  assign iss_last  = ({1'b0, idx_q} == (len_q - LEN_W'(1)));
  assign issue     = (state == ST_RUN) && bank_free[iss_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid && len_ok) begin
            state    <= ST_RUN;
            addr_q   <= req_base;
            stride_q <= req_stride;
            len_q    <= req_len;
            wr_q     <= req_write;
            idx_q    <= '0;
          end
        end
        ST_RUN: begin
          if (issue) begin
            addr_q <= addr_q + stride_q;
            idx_q  <= idx_q + 1'b1;
            if (iss_last) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (ret_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbm_bank_timers.sv
module sbm_bank_timers #(
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int CNT_W      = $clog2(BUSY_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] free
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (issue && (bank == BANK_W'(b))) begin
        cnt <= CNT_W'(BUSY_CYCLES - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
    assign free[b] = (cnt == '0);
  end
endmodule

// File: rtl/sbm_bank_ram.sv
module sbm_bank_ram #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/sbm_ret_pipe.sv
module sbm_ret_pipe #(
  parameter int LATENCY = 12,
  parameter int IDX_W   = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_read,
  input  logic              in_last,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] ram_q,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  typedef struct packed {
    logic             v;
    logic             rd;
    logic             last;
    logic [IDX_W-1:0] idx;
  } tag_t;

  tag_t              tags [LATENCY];
  logic [DATA_W-1:0] dq   [1:LATENCY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LATENCY; k++) tags[k] <= '0;
    end else begin
      tags[0] <= '{v: in_valid, rd: in_read, last: in_last, idx: in_idx};
      for (int k = 1; k < LATENCY; k++) tags[k] <= tags[k-1];
    end
  end

  always_ff @(posedge clk) begin
    dq[1] <= ram_q;
    for (int k = 2; k < LATENCY; k++) dq[k] <= dq[k-1];
  end

  assign rd_valid = tags[LATENCY-1].v && tags[LATENCY-1].rd;
  assign rd_idx   = tags[LATENCY-1].idx;
  assign rd_data  = dq[LATENCY-1];
  assign done     = tags[LATENCY-1].v && tags[LATENCY-1].last;
endmodule

// File: rtl/strided_bank_mem.sv
module strided_bank_mem #(
  parameter int NUM_BANKS   = 16,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int BUSY_CYCLES = 4,
  parameter int LATENCY     = 12,
  parameter int MAX_VLEN    = 64,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int ROW_W      = ADDR_W - BANK_W,
  localparam int IDX_W      = $clog2(MAX_VLEN),
  localparam int LEN_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_stride,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic [IDX_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_data,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic                 issue;
  logic [ADDR_W-1:0]    iss_addr;
  logic [BANK_W-1:0]    iss_bank;
  logic [IDX_W-1:0]     iss_idx;
  logic                 iss_last;
  logic                 iss_write;
  logic [NUM_BANKS-1:0] bank_free;
  logic [BANK_W-1:0]    bsel_q;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
  logic [DATA_W-1:0]    ram_q;

  sbm_agen #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MAX_VLEN(MAX_VLEN)
  ) u_agen (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_base(req_base),
    .req_stride(req_stride), .req_len(req_len),
    .bank_free(bank_free), .ret_done(done),
    .req_ready(req_ready), .issue(issue), .iss_addr(iss_addr),
    .iss_bank(iss_bank), .iss_idx(iss_idx), .iss_last(iss_last),
    .iss_write(iss_write)
  );

  sbm_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_timers (
    .clk(clk), .rst(rst), .issue(issue), .bank(iss_bank), .free(bank_free)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ram
    sbm_bank_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk),
      .en(issue && (iss_bank == BANK_W'(b))),
      .we(iss_write),
      .row(iss_addr[ADDR_W-1:BANK_W]),
      .wdata(st_data),
      .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bsel_q <= '0;
    else if (issue) bsel_q <= iss_bank;
  end

  assign ram_q  = bank_rd[bsel_q];
  assign st_idx = iss_idx;

  sbm_ret_pipe #(
    .LATENCY(LATENCY), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_ret (
    .clk(clk), .rst(rst),
    .in_valid(issue), .in_read(!iss_write), .in_last(iss_last),
    .in_idx(iss_idx), .ram_q(ram_q),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );
endmodule

// File: rtl/sbm_chk.sv
module sbm_chk #(
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  parameter int IDX_W       = 6,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              done,
  input logic              issue,
  input logic [BANK_W-1:0] bank
);
  logic [CW-1:0]    since [NUM_BANKS];
  logic             have_prev;
  logic [IDX_W-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) since[b] <= CW'(BUSY_CYCLES);
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (issue && (bank == BANK_W'(b))) since[b] <= CW'(1);
        else if (since[b] < CW'(BUSY_CYCLES)) since[b] <= since[b] + 1'b1;
      end
      if (rd_valid) prev_idx <= rd_idx;
      if (done) have_prev <= 1'b0;
      else if (rd_valid) have_prev <= 1'b1;
    end
  end

  AST_BANK_REST: assert property (@(posedge clk) disable iff (rst)
    issue |-> (since[bank] >= CW'(BUSY_CYCLES)));  // R5
  AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !have_prev) |-> (rd_idx == '0));  // R7
  AST_IDX_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && have_prev) |-> (rd_idx == prev_idx + 1'b1));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
    issue |-> !req_ready);  // R9
  AST_NO_RET_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !req_ready);  // R9
endmodule

bind strided_bank_mem sbm_chk #(
  .NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_idx(rd_idx), .done(done), .issue(issue), .bank(iss_bank)
);

// File: tb/tb_strided_bank_mem.sv
`timescale 1ns/1ps
module tb_strided_bank_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_base = '0;
  logic [9:0]  req_stride = '0;
  logic [6:0]  req_len = '0;
  logic        req_ready;
  logic [5:0]  st_idx;
  logic [31:0] st_data;
  logic        rd_valid;
  logic [5:0]  rd_idx;
  logic [31:0] rd_data;
  logic        done;
  logic [15:0] cur_tag = 16'h0;

  strided_bank_mem dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_base(req_base), .req_stride(req_stride), .req_len(req_len),
    .req_ready(req_ready), .st_idx(st_idx), .st_data(st_data),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  always #10 clk = ~clk;
  assign st_data = {cur_tag, 10'd0, st_idx};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_done = 0, last_done = 0;
  logic [31:0] model [1024];
  int free_at [16];
  int e_idx[$], e_cyc[$], d_cyc[$];
  logic [31:0] e_dat[$];
  string e_tag[$], d_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (e_idx.size() == 0) begin
          chk(0, "R9", "unexpected return, idx", rd_idx, -1);
        end else begin
          int xi, xc; logic [31:0] xd; string xt;
          xi = e_idx.pop_front(); xc = e_cyc.pop_front();
          xd = e_dat.pop_front(); xt = e_tag.pop_front();
          chk(rd_idx == 6'(xi), {xt, " R7"}, "return index", rd_idx, xi);
          chk(rd_data == xd, {xt, " R2"}, "return data", rd_data, xd);
          chk(cyc == xc, {xt, " R4"}, "return cycle", cyc, xc);
        end
      end
      if (done) begin
        n_done++;
        last_done = cyc;
        if (d_cyc.size() == 0) begin
          chk(0, "R8", "unexpected done, cycle", cyc, -1);
        end else begin
          int dc; string dt;
          dc = d_cyc.pop_front(); dt = d_tag.pop_front();
          chk(cyc == dc, {dt, " R8"}, "done cycle", cyc, dc);
        end
      end
    end
  end

  // Driver: issues one request and pushes expected items
  task automatic run_vec(input bit wr, input int base, input int stride,
                         input int len, input string tag, output int acc);
    int t, a, b;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (wr) cur_tag = cur_tag + 16'd1;
    req_valid = 1'b1; req_write = wr;
    req_base = 10'(base); req_stride = 10'(stride); req_len = 7'(len);
    acc = cyc;
    t = acc + 1;
    for (int i = 0; i < len; i++) begin
      a = (base + i * stride) & 1023;
      b = a & 15;
      if (free_at[b] > t) t = free_at[b];
      free_at[b] = t + 4;
      if (wr) model[a] = {cur_tag, 10'd0, i[5:0]};
      else begin
        e_idx.push_back(i); e_cyc.push_back(t + 12);
        e_dat.push_back(model[a]); e_tag.push_back(tag);
      end
      if (i == len - 1) begin d_cyc.push_back(t + 12); d_tag.push_back(tag); end
      t++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || e_idx.size() != 0 || d_cyc.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int acc, nd;
    for (int b = 0; b < 16; b++) free_at[b] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rd_valid && !done, "R1", "idle after reset",
        {req_ready, rd_valid, done}, 3'b100);

    // R3: fill the whole space with unit-stride stores
    for (int k = 0; k < 16; k++) begin
      run_vec(1, k * 64, 1, 64, "R3", acc);
      wait_idle();
      chk(last_done - acc == 76, "R3 R8", "store done span", last_done - acc, 76);
    end

    // R6: unit stride load runs at one per cycle
    run_vec(0, 0, 1, 64, "R6", acc); wait_idle();
    chk(last_done - acc == 76, "R6", "unit-stride span", last_done - acc, 76);

    // R5: stride 16, same bank every element
    run_vec(0, 5, 16, 8, "R5", acc); wait_idle();
    chk(last_done - acc == 41, "R5", "same-bank span", last_done - acc, 41);

    // R5: stride 8, two banks alternate
    run_vec(0, 3, 8, 8, "R5", acc); wait_idle();
    chk(last_done - acc == 26, "R5", "two-bank span", last_done - acc, 26);

    // R2: stride 2, eight banks, no stall
    run_vec(0, 100, 2, 16, "R2", acc); wait_idle();
    chk(last_done - acc == 28, "R2", "stride-2 span", last_done - acc, 28);

    // R2: downward stride wrapping through zero
    run_vec(0, 10, 1023, 20, "R2", acc); wait_idle();

    // R4 R10: single element
    run_vec(0, 777, 5, 1, "R4 R10", acc); wait_idle();
    chk(last_done - acc == 13, "R4", "one-element latency", last_done - acc, 13);

    // R3: strided store with wrap, then read back with same pattern
    run_vec(1, 900, 17, 30, "R3", acc); wait_idle();
    run_vec(0, 900, 17, 30, "R3", acc); wait_idle();

    // R9: stray store request while a long load runs
    run_vec(0, 2, 16, 64, "R9", acc);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R9", "req_ready while busy", req_ready, 0);
      req_valid = 1'b1; req_write = 1'b1; req_base = 10'd0;
      req_stride = 10'd1; req_len = 7'd64;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_idle();
    chk(last_done - acc == 265, "R9 R5", "long same-bank span", last_done - acc, 265);
    run_vec(0, 0, 1, 64, "R9", acc); wait_idle();

    // R10: zero length is ignored
    nd = n_done;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_base = 10'd0;
    req_stride = 10'd1; req_len = 7'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_done == nd, "R10", "done count after zero length", n_done, nd);
    chk(req_ready == 1'b1, "R10", "idle after zero length", req_ready, 1);

    // R10: short length on a new stride
    run_vec(0, 33, 3, 5, "R10", acc); wait_idle();

    chk(e_idx.size() == 0 && d_cyc.size() == 0, "R7", "scoreboard left",
        e_idx.size() + d_cyc.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule